// File: doc/BRIEF.md
# Stage Strobe Sequencer

This block paces a control datapath that is evaluated one stage at a time. It runs from the system clock and, while enabled, issues a single-cycle enable strobe to each stage in turn. Stage 1 goes first and the last stage goes last. Every strobe is followed by a fixed gap of idle cycles. After the last stage a guard gap of the same length follows, and then the frame starts again. A frame therefore lasts the number of stages times the gap, and the datapath hands one result per frame to its consumer, such as a PWM generator. The default build drives 19 stages with a 100-cycle gap, giving a 1900-cycle frame (38 us at 50 MHz). A 10-stage build with the same gap gives a 1000-cycle frame (20 us).

A run input starts the sequence from idle. When run is dropped, the frame in progress finishes and the sequence then halts. A frame-start marker goes high together with the stage 1 strobe so that downstream logic can align to frame boundaries.

Top module: `stage_strobe_seq`

## Requirements
- R1: After reset, and while idle with run low, every bit of stage_en and frame_start is 0.
- R2: From idle, when run is high at a rising edge, stage_en equals 1 (bit 0 only) in the cycle that follows that edge.
- R3: Each stage_en bit is high for exactly one clock cycle per frame.
- R4: stage_en is one-hot or zero in every cycle, and a frame raises bit 0, bit 1, ... bit NUM_STAGES-1 in ascending order, NUM_STAGES strobes in all.
- R5: Within a frame, bit k rises exactly k*STAGE_GAP cycles after bit 0 (100 cycles between neighbours by default).
- R6: With run held high, bit 0 rises again NUM_STAGES*STAGE_GAP cycles after the previous bit 0 (1900 by default), which leaves a guard gap of STAGE_GAP cycles after the last stage.
- R7: Run is sampled only at the last cycle of a frame. If run is low there, the sequence goes idle. Lowering run earlier, or pulsing it low mid-frame, never cuts a frame short and never delays the next one.
- R8: frame_start is high exactly in the cycles where stage_en bit 0 is high.
- R9: From idle after a stop, raising run restarts the sequence at bit 0 on the cycle after the sampling edge.
- R10: Asserting rst_n low mid-frame clears all outputs at once and returns the block to idle. The first frame after release behaves as in R2.
- R11: With NUM_STAGES=10 and STAGE_GAP=100, the frame is 1000 cycles and bit 9 rises 900 cycles after bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables the sequence; sampled at frame ends while running |
| stage_en | output | NUM_STAGES | One-hot stage enable strobes, bit 0 = first stage |
| frame_start | output | 1 | High with the first stage strobe of each frame |

## Verification
On every cycle, the embedded assertions check the strobe shape. They confirm one-hot output, single-cycle pulses, an exact gap and the correct predecessor before each later stage, a guard of at least one gap before stage 1 is reissued, and agreement of the frame marker with stage 1. The assertions cannot show how run is honoured only at the frame boundary, whether a stop lands on the exact last cycle, how a reset mid-frame takes effect, or how the 10-stage build's frame length comes out. The bench's directed scenarios show these by comparing every cycle against a position model driven by the requirements.

// File: rtl/seq_pkg.sv
package seq_pkg;

  // cycles in one complete frame: every stage slot plus the trailing guard
  function automatic int unsigned frame_cycles(int unsigned stages, int unsigned gap);
    return stages * gap;
  endfunction

  // offset of a stage strobe from the start of its frame
  function automatic int unsigned strobe_offset(int unsigned stage, int unsigned gap);
    return stage * gap;
  endfunction

endpackage

// File: rtl/seq_tick_div.sv
module seq_tick_div #(
  parameter int unsigned GAP = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic at_zero,
  output logic at_last
);
  localparam int unsigned W = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [W-1:0] LAST = W'(GAP - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (hold)         cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + W'(1);
  end

  assign at_zero = (cnt == '0);
  assign at_last = (cnt == LAST);

  // the divider must sit at zero whenever it has been held
  AST_TICK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> at_zero); // R2
endmodule

// File: rtl/seq_slot_ctr.sv
module seq_slot_ctr #(
  parameter int unsigned N  = 19,
  parameter int unsigned SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          step,
  output logic [SW-1:0] slot,
  output logic          at_last
);
  localparam logic [SW-1:0] LAST = SW'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      slot <= '0;
    else if (hold)   slot <= '0;
    else if (step)   slot <= (slot == LAST) ? '0 : slot + SW'(1);
  end

  assign at_last = (slot == LAST);

  // the slot index never leaves the stage range
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= LAST); // R4
endmodule

// File: rtl/seq_strobe_dec.sv
module seq_strobe_dec #(
  parameter int unsigned N  = 19,
  parameter int unsigned SW = $clog2(N)
) (
  input  logic          fire,
  input  logic [SW-1:0] slot,
  output logic [N-1:0]  strobes
);
  for (genvar g = 0; g < N; g++) begin : g_strobe
    assign strobes[g] = fire && (slot == SW'(g));
  end
endmodule

// File: rtl/stage_strobe_seq.sv
module stage_strobe_seq #(
  parameter int unsigned NUM_STAGES = 19,
  parameter int unsigned STAGE_GAP  = 100
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  output logic [NUM_STAGES-1:0] stage_en,
  output logic                  frame_start
);
  localparam int unsigned SW           = $clog2(NUM_STAGES);
  localparam int unsigned FRAME_CYCLES = seq_pkg::frame_cycles(NUM_STAGES, STAGE_GAP);
  localparam int unsigned GAPW         = $clog2(FRAME_CYCLES + 1);

  logic          active;
  logic          hold;
  logic          tick_zero;
  logic          tick_last;
  logic          slot_last;
  logic          launch;
  logic          frame_end;
  logic          fire;
  logic [SW-1:0] slot;

  assign hold = !active;

  seq_tick_div #(.GAP(STAGE_GAP)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (hold),
    .at_zero (tick_zero),
    .at_last (tick_last)
  );

  seq_slot_ctr #(.N(NUM_STAGES), .SW(SW)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (hold),
    .step    (tick_last),
    .slot    (slot),
    .at_last (slot_last)
  );

  assign fire = active && tick_zero;

  seq_strobe_dec #(.N(NUM_STAGES), .SW(SW)) u_dec (
    .fire    (fire),
    .slot    (slot),
    .strobes (stage_en)
  );

  assign frame_start = fire && (slot == '0);

  // run is consulted only from idle and at the final cycle of a frame
  assign launch    = !active && run;
  assign frame_end = active && tick_last && slot_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         active <= 1'b0;
    else if (launch)    active <= 1'b1;
    else if (frame_end) active <= run;
  end

  // ---------------- assertion support: history of the last strobe ----------
  logic [GAPW-1:0] gap;
  logic [SW-1:0]   last_idx;
  logic [SW-1:0]   cur_idx;
  logic            last_valid;
  logic            any_strobe;

  always_comb begin
    cur_idx = '0;
    for (int i = 0; i < int'(NUM_STAGES); i++)
      if (stage_en[i]) cur_idx = SW'(i);
  end

  assign any_strobe = |stage_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap        <= '0;
      last_idx   <= '0;
      last_valid <= 1'b0;
    end else if (any_strobe) begin
      gap        <= GAPW'(1);
      last_idx   <= cur_idx;
      last_valid <= 1'b1;
    end else if (gap != GAPW'(FRAME_CYCLES)) begin
      gap <= gap + GAPW'(1);
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stage_en)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !run) |=> (stage_en == '0)); // R1

  AST_FRAME_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start == stage_en[0]); // R8

  AST_FRAME_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_en[0] && last_valid) |-> (last_idx == SW'(NUM_STAGES - 1) && gap >= GAPW'(STAGE_GAP))); // R6

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_chk
    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      stage_en[g] |=> !stage_en[g]); // R3
    if (g > 0) begin : g_order
      AST_STROBE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        stage_en[g] |-> (last_valid && last_idx == SW'(g - 1) && gap == GAPW'(STAGE_GAP))); // R5
    end
  end
endmodule

// File: tb/stage_strobe_seq_tb.sv
module stage_strobe_seq_tb;
  localparam int SP = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_a = 1'b0;
  logic        run_b = 1'b0;
  logic [18:0] en_a;
  logic [9:0]  en_b;
  logic        fs_a, fs_b;

  int checks = 0;
  int errors = 0;
  int strobes_seen = 0;
  bit done = 0;

  int m_act[2];
  int m_pos[2];

  always #10 clk = ~clk;

  stage_strobe_seq u_dut (
    .clk(clk), .rst_n(rst_n), .run(run_a), .stage_en(en_a), .frame_start(fs_a));

  stage_strobe_seq #(.NUM_STAGES(10), .STAGE_GAP(100)) u_dut10 (
    .clk(clk), .rst_n(rst_n), .run(run_b), .stage_en(en_b), .frame_start(fs_b));

  function automatic int stages_of(int sel);
    return (sel == 0) ? 19 : 10;
  endfunction

  task automatic report;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic check_now(int sel, string tag);
    logic [18:0] got, exp;
    logic gfs, efs;
    got = (sel == 0) ? en_a : {9'b0, en_b};
    gfs = (sel == 0) ? fs_a : fs_b;
    exp = '0;
    efs = 1'b0;
    if (m_act[sel] != 0 && (m_pos[sel] % SP) == 0) begin
      exp[m_pos[sel] / SP] = 1'b1;
      efs = (m_pos[sel] == 0);
    end
    checks++;
    if (got !== exp || gfs !== efs) begin
      errors++;
      $display("FAIL %s dut%0d pos %0d: stage_en=%h frame_start=%b expected %h %b",
               tag, sel, m_pos[sel], got, gfs, exp, efs);
    end
    if (got != 0) strobes_seen++;
  endtask

  // advance the requirement model past one rising edge, then wait for mid-cycle
  task automatic tick;
    for (int s = 0; s < 2; s++) begin
      int r, frame;
      r = (s == 0) ? int'(run_a) : int'(run_b);
      frame = stages_of(s) * SP;
      if (!rst_n) begin
        m_act[s] = 0; m_pos[s] = 0;
      end else if (m_act[s] != 0) begin
        if (m_pos[s] == frame - 1) begin
          m_pos[s] = 0; m_act[s] = r;
        end else m_pos[s]++;
      end else if (r != 0) begin
        m_act[s] = 1; m_pos[s] = 0;
      end
    end
    @(negedge clk);
  endtask

  task automatic watch(int sel, int n, string tag);
    for (int i = 0; i < n; i++) begin
      check_now(sel, tag);
      tick();
    end
  endtask

  task automatic run_to(int sel, int pos, string tag);
    while (!(m_act[sel] != 0 && m_pos[sel] == pos)) begin
      check_now(sel, tag);
      tick();
    end
  endtask

  task automatic expect_count(int exp, string tag);
    checks++;
    if (strobes_seen != exp) begin
      errors++;
      $display("FAIL %s strobe count %0d expected %0d", tag, strobes_seen, exp);
    end
  endtask

  task automatic t_reset;  // R1
    rst_n = 1'b0;
    m_act = '{0, 0}; m_pos = '{0, 0};
    @(negedge clk);
    check_now(0, "R1 reset");
    check_now(1, "R1 reset");
    rst_n = 1'b1;
    watch(0, 50, "R1 idle");
    watch(1, 5, "R1 idle");
  endtask

  task automatic t_start_frames;  // R2 R3 R4 R5 R6 R8
    run_a = 1'b1;
    check_now(0, "R2 before edge");
    tick();
    check_now(0, "R2 first strobe");
    strobes_seen = 0;
    watch(0, 1900, "R3 R5 frame one");
    watch(0, 1900, "R6 R8 frame two");
    expect_count(38, "R4");
  endtask

  task automatic t_dip_and_stop;  // R7
    run_to(0, 500, "R7 dip");
    run_a = 1'b0;
    run_to(0, 700, "R7 dip low");
    run_a = 1'b1;
    watch(0, 1500, "R7 dip no effect");
    run_to(0, 1899, "R7 to boundary");
    run_a = 1'b0;
    watch(0, 300, "R7 stopped");
  endtask

  task automatic t_restart_late_drop;  // R9 R7
    run_a = 1'b1;
    watch(0, 3, "R9 restart");
    run_a = 1'b0;
    strobes_seen = 0;
    watch(0, 2100, "R7 late drop");
    expect_count(18, "R7 late drop");
  endtask

  task automatic t_reset_mid;  // R10
    run_a = 1'b1;
    run_to(0, 850, "R10 pre");
    rst_n = 1'b0;
    m_act[0] = 0; m_pos[0] = 0;
    #1;
    check_now(0, "R10 async clear");
    @(negedge clk);
    watch(0, 4, "R10 held");
    rst_n = 1'b1;
    watch(0, 300, "R10 after release");
    run_a = 1'b0;
  endtask

  task automatic t_ten;  // R11
    run_b = 1'b1;
    tick();
    strobes_seen = 0;
    watch(1, 2000, "R11 ten stage");
    expect_count(20, "R11");
    run_b = 1'b0;
    watch(1, 1100, "R11 stop");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: 1 expected 0");
    report();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_start_frames();
    t_dip_and_stop();
    t_restart_late_drop();
    t_reset_mid();
    t_ten();
    report();
  end
endmodule